// File: doc/BRIEF.md
# ATA PIO cycle timing sequencer

This block sits on the host side of a two-drive ATA channel and turns a CPU-side access request into one programmed-I/O cycle on the drive bus. A cycle has three phases. First the drive address and select are presented with both strobes inactive. Then the read or write strobe is held active for a programmed number of clocks. Last comes a programmed recovery interval with both strobes inactive. Completion is reported by a one-cycle pulse, and a busy flag covers the whole cycle.

Each drive's timing is packed into one byte. The data-pulse and recovery counts are stored offset-encoded, and each drive keeps separate bytes for reads and for writes. The address-setup count is shared by both drives and lives in a common miscellaneous byte. That byte also carries a ready-sampling code and a read-prefetch enable; both are only held here and brought out to neighbouring logic. A small register write port loads all of these bytes. A control write chooses whether the two drives use separate timing sets or share the first set.

Timing values are latched when a request is accepted. A running cycle is therefore never disturbed by reprogramming.

Top module: `ata_pio_seq`

## Requirements
- R1: After reset, every timing byte is 0xFF and the shared setup field is 3, so any cycle has a 4-clock setup, a 16-clock strobe and a 17-clock recovery. In the same state the ready code output is 3, prefetch is off, busy, done and output enable are low, and both strobes are high.
- R2: A timing byte gives the strobe width as bits 7:4 plus 1 clocks (1 to 16) and the recovery length as bits 3:0 plus 2 clocks (2 to 17).
- R3: Config address 0 writes the read-cycle byte and address 1 writes the write-cycle byte of the currently chosen set. Read cycles use only the read byte and write cycles use only the write byte.
- R4: A write to config address 6 loads the shared fields. Bits 5:4 plus 1 give the setup length (1 to 4 clocks) for both drives. Bit 6 drives `prefetch_en`, and bits 2:1 drive `drdy_code`.
- R5: Bit 0 of every config-address-6 write chooses the set (0 = set A, 1 = set B) that later writes to addresses 0 and 1 update.
- R6: Writing exactly 0x85 to config address 3 maps drive 0 to set A and drive 1 to set B. Any other value written there, and the reset state, makes both drives use set A.
- R7: A cycle runs its setup clocks with both strobes high, then its strobe clocks, then its recovery clocks with both strobes high. Address and drive select stay valid for the whole cycle.
- R8: Only the read strobe goes low in a read cycle and only the write strobe in a write cycle. During a write cycle the write data is driven with the output enable high for the whole cycle; the enable is low otherwise.
- R9: In a read cycle, `rdata` takes the bus value present in the last strobe clock, captured on the edge that ends the strobe.
- R10: A request is accepted only when the block is idle. Busy is high from the edge that accepts it until recovery ends, and `done` pulses for the one idle clock that follows. A request held high during a cycle is accepted only on the edge after `done`.
- R11: Config writes made while a cycle runs do not change that cycle's setup, strobe or recovery lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Config write enable |
| cfg_addr | input | 3 | Config register address |
| cfg_wdata | input | 8 | Config write data |
| req | input | 1 | Access request, level, held until accepted |
| req_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| req_drive | input | 1 | Target drive (0 or 1) |
| req_addr | input | 3 | Drive register address for the cycle |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Data captured by the last read cycle |
| ata_addr | output | 3 | Drive register address on the bus |
| ata_dev_sel | output | 1 | Drive select on the bus |
| rd_stb_n | output | 1 | Read strobe, active low |
| wr_stb_n | output | 1 | Write strobe, active low |
| dd_out | output | 16 | Bus data driven during writes |
| dd_oe | output | 1 | Bus data output enable |
| dd_in | input | 16 | Bus data from the drive |
| prefetch_en | output | 1 | Read-prefetch enable from the shared byte |
| drdy_code | output | 2 | Ready-sampling code from the shared byte |

## Verification
The properties assume a requester that keeps `req` and its qualifiers steady until `busy` rises. They also assume `rst_n` is applied before any request. The bench holds every request steady until it sees `busy` and drives all inputs half a period away from the sampling edge. It replays each cycle phase by phase, counting setup, strobe and recovery clocks against lengths computed from its own model of the timing bytes. Random programming and random cycles are mixed with directed cases: minimum and maximum encodings, set remapping, a request held across recovery, and reprogramming in the middle of a cycle.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
    localparam int N_SETS = 2;
    localparam int SET_W  = (N_SETS > 1) ? $clog2(N_SETS) : 1;

    localparam logic [2:0] CFG_RD_TIM = 3'd0;
    localparam logic [2:0] CFG_WR_TIM = 3'd1;
    localparam logic [2:0] CFG_CTRL   = 3'd3;
    localparam logic [2:0] CFG_MISC   = 3'd6;

    localparam logic [7:0] CTRL_SPLIT = 8'h85;
    localparam logic [7:0] TIM_SLOW   = 8'hFF;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_RECOV  = 2'd3
    } phase_e;

    // bits 7:4 pulse clocks minus one, bits 3:0 recovery clocks minus two
    typedef struct packed {
        logic [3:0] pulse_m1;
        logic [3:0] recov_m2;
    } tim_t;
endpackage

// File: rtl/ata_pio_regs.sv
module ata_pio_regs
    import ata_pio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [2:0] cfg_addr,
    input  logic [7:0] cfg_wdata,
    input  logic       sel_wr,
    input  logic       sel_drive,
    output tim_t       sel_tim,
    output logic [1:0] setup_m1,
    output logic       prefetch_en,
    output logic [1:0] drdy_code
);
    typedef struct packed {
        tim_t [N_SETS-1:0] rd;
        tim_t [N_SETS-1:0] wr;
        logic [1:0]        setup_m1;
        logic [1:0]        drdy;
        logic              pf;
        logic [SET_W-1:0]  bank;
        logic              split;
    } regs_t;

    regs_t s_d, s_q;
    logic [SET_W-1:0] set_idx;

    always_comb begin
        s_d = s_q;
        if (cfg_we) begin
            unique case (cfg_addr)
                CFG_RD_TIM: s_d.rd[s_q.bank] = tim_t'(cfg_wdata);
                CFG_WR_TIM: s_d.wr[s_q.bank] = tim_t'(cfg_wdata);
                CFG_CTRL:   s_d.split = (cfg_wdata == CTRL_SPLIT);
                CFG_MISC: begin
                    s_d.setup_m1 = cfg_wdata[5:4];
                    s_d.drdy     = cfg_wdata[2:1];
                    s_d.pf       = cfg_wdata[6];
                    s_d.bank     = cfg_wdata[SET_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SETS; i++) begin
                s_q.rd[i] <= tim_t'(TIM_SLOW);
                s_q.wr[i] <= tim_t'(TIM_SLOW);
            end
            s_q.setup_m1 <= 2'd3;
            s_q.drdy     <= 2'd3;
            s_q.pf       <= 1'b0;
            s_q.bank     <= '0;
            s_q.split    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        set_idx = s_q.split ? SET_W'(sel_drive) : '0;
        sel_tim = sel_wr ? s_q.wr[set_idx] : s_q.rd[set_idx];
    end

    assign setup_m1    = s_q.setup_m1;
    assign prefetch_en = s_q.pf;
    assign drdy_code   = s_q.drdy;
endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
    import ata_pio_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic              req_drive,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  tim_t              tim_in,
    input  logic [1:0]        setup_m1,
    input  logic [DATA_W-1:0] dd_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] ata_addr,
    output logic              ata_dev_sel,
    output logic              rd_stb_n,
    output logic              wr_stb_n,
    output logic [DATA_W-1:0] dd_out,
    output logic              dd_oe
);
    localparam int CNT_W = $clog2(18);

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        tim_t              tim;
        logic              wr;
        logic              drive;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } eng_t;

    eng_t e_d, e_q;

    always_comb begin
        e_d      = e_q;
        e_d.done = 1'b0;
        unique case (e_q.ph)
            PH_IDLE: begin
                if (req) begin
                    e_d.ph    = PH_SETUP;
                    e_d.cnt   = CNT_W'(setup_m1);
                    e_d.tim   = tim_in;
                    e_d.wr    = req_wr;
                    e_d.drive = req_drive;
                    e_d.addr  = req_addr;
                    e_d.wdata = req_wdata;
                end
            end
            PH_SETUP: begin
                if (e_q.cnt == '0) begin
                    e_d.ph  = PH_ACTIVE;
                    e_d.cnt = CNT_W'(e_q.tim.pulse_m1);
                end else begin
                    e_d.cnt = e_q.cnt - CNT_W'(1);
                end
            end
            PH_ACTIVE: begin
                if (e_q.cnt == '0) begin
                    e_d.ph  = PH_RECOV;
                    e_d.cnt = CNT_W'(e_q.tim.recov_m2) + CNT_W'(1);
                    if (!e_q.wr) e_d.rdata = dd_in;
                end else begin
                    e_d.cnt = e_q.cnt - CNT_W'(1);
                end
            end
            PH_RECOV: begin
                if (e_q.cnt == '0) begin
                    e_d.ph   = PH_IDLE;
                    e_d.done = 1'b1;
                end else begin
                    e_d.cnt = e_q.cnt - CNT_W'(1);
                end
            end
            default: e_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign busy        = (e_q.ph != PH_IDLE);
    assign done        = e_q.done;
    assign rdata       = e_q.rdata;
    assign ata_addr    = e_q.addr;
    assign ata_dev_sel = e_q.drive;
    assign rd_stb_n    = !((e_q.ph == PH_ACTIVE) && !e_q.wr);
    assign wr_stb_n    = !((e_q.ph == PH_ACTIVE) && e_q.wr);
    assign dd_out      = e_q.wdata;
    assign dd_oe       = busy && e_q.wr;
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
    import ata_pio_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              req,
    input  logic              req_wr,
    input  logic              req_drive,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] ata_addr,
    output logic              ata_dev_sel,
    output logic              rd_stb_n,
    output logic              wr_stb_n,
    output logic [DATA_W-1:0] dd_out,
    output logic              dd_oe,
    input  logic [DATA_W-1:0] dd_in,
    output logic              prefetch_en,
    output logic [1:0]        drdy_code
);
    tim_t       sel_tim;
    logic [1:0] setup_m1;

    ata_pio_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .sel_wr      (req_wr),
        .sel_drive   (req_drive),
        .sel_tim     (sel_tim),
        .setup_m1    (setup_m1),
        .prefetch_en (prefetch_en),
        .drdy_code   (drdy_code)
    );

    ata_pio_engine #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .req_wr      (req_wr),
        .req_drive   (req_drive),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .tim_in      (sel_tim),
        .setup_m1    (setup_m1),
        .dd_in       (dd_in),
        .busy        (busy),
        .done        (done),
        .rdata       (rdata),
        .ata_addr    (ata_addr),
        .ata_dev_sel (ata_dev_sel),
        .rd_stb_n    (rd_stb_n),
        .wr_stb_n    (wr_stb_n),
        .dd_out      (dd_out),
        .dd_oe       (dd_oe)
    );
endmodule

// File: rtl/ata_pio_chk.sv
module ata_pio_chk #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              rd_stb_n,
    input logic              wr_stb_n,
    input logic              dd_oe,
    input logic [ADDR_W-1:0] ata_addr,
    input logic              ata_dev_sel
);
    a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_n || wr_stb_n));

    a_r7_strobe_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb_n || !wr_stb_n) |-> busy);

    a_r7_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (rd_stb_n && wr_stb_n));

    a_r7_recov_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_stb_n) || $rose(wr_stb_n)) |-> busy);

    a_r8_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb_n |-> !dd_oe);

    a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r10_done_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r7_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(ata_addr) && $stable(ata_dev_sel)));
endmodule

bind ata_pio_seq ata_pio_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .rd_stb_n    (rd_stb_n),
    .wr_stb_n    (wr_stb_n),
    .dd_oe       (dd_oe),
    .ata_addr    (ata_addr),
    .ata_dev_sel (ata_dev_sel)
);

// File: tb/ata_pio_seq_tb.sv
module ata_pio_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        req = 1'b0, req_wr = 1'b0, req_drive = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] dd_in = '0;
    logic        busy, done, ata_dev_sel, rd_stb_n, wr_stb_n, dd_oe, prefetch_en;
    logic [15:0] rdata, dd_out;
    logic [2:0]  ata_addr;
    logic [1:0]  drdy_code;

    int n_chk = 0;
    int n_bad = 0;

    // bench model of the programmed state
    logic [7:0] m_rd [2];
    logic [7:0] m_wr [2];
    logic [1:0] m_setup_m1;
    logic [1:0] m_drdy;
    logic       m_pf, m_bank, m_split;

    always #5 clk = ~clk;

    ata_pio_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req(req), .req_wr(req_wr), .req_drive(req_drive),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rdata(rdata), .ata_addr(ata_addr), .ata_dev_sel(ata_dev_sel),
        .rd_stb_n(rd_stb_n), .wr_stb_n(wr_stb_n), .dd_out(dd_out), .dd_oe(dd_oe),
        .dd_in(dd_in), .prefetch_en(prefetch_en), .drdy_code(drdy_code)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < 2; i++) begin m_rd[i] = 8'hFF; m_wr[i] = 8'hFF; end
        m_setup_m1 = 2'd3; m_drdy = 2'd3; m_pf = 1'b0; m_bank = 1'b0; m_split = 1'b0;
    endfunction

    function automatic void model_cfg(input logic [2:0] a, input logic [7:0] d);
        case (a)
            3'd0: m_rd[m_bank] = d;
            3'd1: m_wr[m_bank] = d;
            3'd3: m_split = (d == 8'h85);
            3'd6: begin
                m_setup_m1 = d[5:4]; m_drdy = d[2:1]; m_pf = d[6]; m_bank = d[0];
            end
            default: ;
        endcase
    endfunction

    function automatic logic [7:0] exp_byte(input bit wr, input bit drv);
        int s = m_split ? int'(drv) : 0;
        return wr ? m_wr[s] : m_rd[s];
    endfunction

    task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        model_cfg(a, d);
    endtask

    // Runs one cycle from the idle state and measures its phases.
    task automatic run_cycle(input bit wr, input bit drv, input logic [2:0] a,
                             input logic [15:0] wd, input bit hold,
                             input bit mid, input logic [2:0] ma, input logic [7:0] md);
        logic [7:0]  eb = exp_byte(wr, drv);
        int          e_s = int'(m_setup_m1) + 1;
        int          e_d = int'(eb[7:4]) + 1;
        int          e_r = int'(eb[3:0]) + 2;
        int          s = 0, d = 0, r = 0, guard = 0;
        bit          bad_stb = 0, bad_bus = 0;
        logic [15:0] last = '0;
        string       tl = mid ? "R11" : "R2";
        @(negedge clk);
        req = 1'b1; req_wr = wr; req_drive = drv; req_addr = a; req_wdata = wd;
        @(negedge clk);
        check(busy == 1'b1, "R10 accept", int'(busy), 1);
        if (!hold) req = 1'b0;
        while (busy && guard < 100) begin
            logic [15:0] v = 16'($urandom);
            bit low = wr ? !wr_stb_n : !rd_stb_n;
            guard++;
            if (wr ? !rd_stb_n : !wr_stb_n) bad_stb = 1;
            if (ata_addr != a || ata_dev_sel != drv) bad_bus = 1;
            if (wr && (!dd_oe || dd_out != wd)) bad_stb = 1;
            if (!wr && dd_oe) bad_stb = 1;
            if (low) begin
                d++;
                if (r != 0) bad_bus = 1;
                last = v;
            end else if (d == 0) s++;
            else r++;
            dd_in = v;
            if (mid && guard == 2) begin cfg_we = 1'b1; cfg_addr = ma; cfg_wdata = md; end
            if (mid && guard == 3) cfg_we = 1'b0;
            @(negedge clk);
        end
        cfg_we = 1'b0;
        if (mid) model_cfg(ma, md);
        check(s == e_s, mid ? "R11 setup" : "R4 setup", s, e_s);
        check(d == e_d, {tl, " strobe"}, d, e_d);
        check(r == e_r, {tl, " recovery"}, r, e_r);
        check(!bad_stb, "R8 strobe/oe", int'(bad_stb), 0);
        check(!bad_bus, "R7 order/address", int'(bad_bus), 0);
        check(done == 1'b1, "R10 done pulse", int'(done), 1);
        if (!wr) check(rdata == last, "R9 rdata", int'(rdata), int'(last));
        if (hold) begin
            @(negedge clk);
            check(busy == 1'b1, "R10 held request accepted after done", int'(busy), 1);
            check(done == 1'b0, "R10 done single pulse", int'(done), 0);
            req = 1'b0;
            guard = 0;
            while (busy && guard < 100) begin guard++; @(negedge clk); end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0A7A));
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 0 && done == 0 && dd_oe == 0, "R1 idle outputs", int'(busy), 0);
        check(rd_stb_n && wr_stb_n, "R1 strobes high", int'({rd_stb_n, wr_stb_n}), 3);
        check(prefetch_en == 0, "R1 prefetch", int'(prefetch_en), 0);
        check(drdy_code == 2'd3, "R1 ready code", int'(drdy_code), 3);
        rst_n = 1'b1;
        // R1 slowest default cycles
        run_cycle(1'b0, 1'b0, 3'd7, 16'h0, 0, 0, 3'd0, 8'h0);
        run_cycle(1'b1, 1'b1, 3'd2, 16'hA55A, 0, 0, 3'd0, 8'h0);
        // program set A then set B (R3, R5)
        cfg_write(3'd6, 8'h00);
        cfg_write(3'd0, 8'h21);
        cfg_write(3'd1, 8'h50);
        cfg_write(3'd6, 8'h01);
        cfg_write(3'd0, 8'h00);
        cfg_write(3'd1, 8'hF0);
        cfg_write(3'd3, 8'h85);
        cfg_write(3'd6, 8'h53);
        @(negedge clk);
        check(prefetch_en == 1'b1, "R4 prefetch bit", int'(prefetch_en), 1);
        check(drdy_code == 2'd1, "R4 ready code", int'(drdy_code), 1);
        run_cycle(1'b0, 1'b0, 3'd1, 16'h0, 0, 0, 3'd0, 8'h0);
        run_cycle(1'b1, 1'b0, 3'd1, 16'h1234, 0, 0, 3'd0, 8'h0);
        run_cycle(1'b0, 1'b1, 3'd0, 16'h0, 0, 0, 3'd0, 8'h0);   // R2 minimum 0x00
        run_cycle(1'b1, 1'b1, 3'd0, 16'hBEEF, 0, 0, 3'd0, 8'h0);
        // R6 shared mapping
        cfg_write(3'd3, 8'h84);
        run_cycle(1'b0, 1'b1, 3'd5, 16'h0, 0, 0, 3'd0, 8'h0);
        cfg_write(3'd3, 8'h85);
        // R10 held request
        run_cycle(1'b0, 1'b1, 3'd3, 16'h0, 1, 0, 3'd0, 8'h0);
        // R11 reprogram during a cycle (bank is B)
        run_cycle(1'b0, 1'b1, 3'd4, 16'h0, 0, 1, 3'd0, 8'hFF);
        run_cycle(1'b1, 1'b1, 3'd4, 16'h7777, 0, 1, 3'd6, 8'h30);
        // random mix
        for (int it = 0; it < 40; it++) begin
            int k = int'($urandom_range(0, 3));
            case (k)
                0: cfg_write(3'd0, 8'($urandom));
                1: cfg_write(3'd1, 8'($urandom));
                2: cfg_write(3'd6, 8'($urandom));
                default: cfg_write(3'd3, ($urandom_range(0, 1) == 1) ? 8'h85 : 8'($urandom));
            endcase
            run_cycle(1'($urandom), 1'($urandom), 3'($urandom), 16'($urandom),
                      1'b0, ($urandom_range(0, 4) == 0), 3'd0, 8'($urandom));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule